// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip trace sink. Each cycle it may receive one 32-bit trace word. While capture is enabled, it writes that word into a circular RAM at the write pointer. When the pointer passes the last location it wraps to zero and raises a sticky overrun flag, which tells software that the oldest words have been overwritten.

Software reaches the block through a simple register port with one access per cycle. Through that port it can:
- set and read back both pointers;
- clear or preload the RAM by writing consecutive words;
- drain the RAM by reading the data register repeatedly, since each read advances the read pointer.

A formatter-control register controls how capture ends. A manual flush pads the current 4-word frame with zero words and then clears its own request bit. Capture can also be told to stop once a flush completes, or once a programmed number of words has been stored after a trigger. A formatter-status bit reports when capture has stopped.

Register offsets: depth 0x004, status 0x00C, read data 0x010, read pointer 0x014, write pointer 0x018, trigger count 0x01C, control 0x020, write data 0x024, formatter status 0x300, formatter control 0x304. DEPTH must be a power of two, at least 4. Pointer values written by software are taken modulo DEPTH.

Top module: `trace_capture_buf`

## Requirements
- R1: A read of offset 0x004 returns DEPTH, and bit 31 of that value is 0.
- R2: Control bit 0 is the capture enable. While it is 0, trace words are ignored and the write pointer holds.
- R3: Each stored word, whether from trace or from a software write to offset 0x024, goes to the write pointer location. The write pointer then advances modulo DEPTH. A software write to 0x024 or 0x018 wins over a trace word in the same cycle, and that trace word is dropped.
- R4: Status bit 0 is set when a store advances the write pointer from DEPTH-1 to 0. It stays set until software writes the write pointer.
- R5: A read of offset 0x010 returns the word at the read pointer. The read pointer then advances modulo DEPTH.
- R6: Both pointers can be written and read back at 0x014 and 0x018. A new value takes effect on the next access.
- R7: When formatter-control bit 13 is set, a trigger input seen during capture arms the stop counter. The word presented in the trigger cycle is stored, then exactly the trigger count (0x01C) more words, and then capture stops.
- R8: Writing formatter-control bit 6 requests a manual flush. The block then stores zero words until the write pointer is a multiple of 4, and then clears bit 6. Bit 6 reads 1 while the flush is pending. Trace input is ignored during the flush.
- R9: When formatter-control bit 12 is set, completing a flush stops capture.
- R10: Formatter-status bit 1 reads 1 when capture is stopped or disabled. While stopped, no word is stored. Writing control with bit 0 = 1 clears the stop and the trigger state.
- R11: After reset, capture is disabled, both pointers are 0, status reads 0, formatter control reads 0, and formatter status reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trace_valid_i | input | 1 | Trace word present this cycle |
| trace_data_i | input | 32 | Trace word |
| trigger_i | input | 1 | Trigger event |
| reg_req_i | input | 1 | Register access this cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |

## Verification
Three kinds of internal fault surface at the ports, each at a different time:
- A wrong write-pointer step shows up at the next read of 0x018. It also shows up one drain later, as words at the wrong read addresses.
- A lost or spurious overrun flag shows up in status bit 0 at the first read after the wrapping store.
- Trigger and flush faults show up as a write pointer that overshoots or undershoots the expected frame boundary. They also appear as formatter bits that still read 1, or already read 0, within a few cycles of the event.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int ADDR_W = 12;
  localparam int REG_W  = 32;
  localparam int FRM_W  = 2;  // log2 of words per frame

  localparam logic [ADDR_W-1:0] A_DEPTH = 12'h004;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_RDATA = 12'h010;
  localparam logic [ADDR_W-1:0] A_RPTR  = 12'h014;
  localparam logic [ADDR_W-1:0] A_WPTR  = 12'h018;
  localparam logic [ADDR_W-1:0] A_TRIG  = 12'h01C;
  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h020;
  localparam logic [ADDR_W-1:0] A_WDATA = 12'h024;
  localparam logic [ADDR_W-1:0] A_FSTAT = 12'h300;
  localparam logic [ADDR_W-1:0] A_FCTRL = 12'h304;

  localparam int FC_FMT   = 0;
  localparam int FC_FLUSH = 6;
  localparam int FC_STFL  = 12;
  localparam int FC_STTRG = 13;
  localparam int FS_STOP  = 1;
endpackage

// File: rtl/tcb_ptr.sv
module tcb_ptr #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign wrap_o = step_i && (ptr_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (step_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_valid_i,
  input  logic [REG_W-1:0]  trace_data_i,
  input  logic              trigger_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [REG_W-1:0] ram_wd, ram_rd;
  logic             ram_we, wrap;
  logic             cap_en_q, stopped_q, full_q, flush_q, armed_q;
  logic             fc_fmt_q, fc_stfl_q, fc_sttrg_q;
  logic [CNT_W-1:0] trig_q, cnt_q;

  logic wr_acc, rd_acc, wr_wptr, wr_rptr, wr_wdata, wr_ctrl, wr_fctrl, wr_trig, rd_data;
  logic sw_owns, restart, live, stop_now, aligned, trace_st, pad_st, hw_st, flush_done, arm;

  assign wr_acc   = reg_req_i && reg_we_i;
  assign rd_acc   = reg_req_i && !reg_we_i;
  assign wr_wptr  = wr_acc && (reg_addr_i == A_WPTR);
  assign wr_rptr  = wr_acc && (reg_addr_i == A_RPTR);
  assign wr_wdata = wr_acc && (reg_addr_i == A_WDATA);
  assign wr_ctrl  = wr_acc && (reg_addr_i == A_CTRL);
  assign wr_fctrl = wr_acc && (reg_addr_i == A_FCTRL);
  assign wr_trig  = wr_acc && (reg_addr_i == A_TRIG);
  assign rd_data  = rd_acc && (reg_addr_i == A_RDATA);

  assign sw_owns    = wr_wptr || wr_wdata;
  assign restart    = wr_ctrl && reg_wdata_i[0];
  assign live       = cap_en_q && !stopped_q;
  assign stop_now   = armed_q && (cnt_q == '0);
  assign aligned    = (wr_ptr[FRM_W-1:0] == '0);
  assign trace_st   = live && trace_valid_i && !flush_q && !stop_now && !sw_owns;
  assign pad_st     = live && flush_q && !aligned && !stop_now && !sw_owns;
  assign hw_st      = trace_st || pad_st;
  assign flush_done = flush_q && (!live || aligned);
  assign arm        = live && fc_sttrg_q && trigger_i && !armed_q;

  assign ram_we = wr_wdata || hw_st;
  assign ram_wd = wr_wdata ? reg_wdata_i : (pad_st ? '0 : trace_data_i);

  tcb_ram #(.DEPTH(DEPTH), .DW(REG_W), .AW(AW)) u_ram (
    .clk_i, .we_i(ram_we), .waddr_i(wr_ptr), .wdata_i(ram_wd),
    .raddr_i(rd_ptr), .rdata_o(ram_rd)
  );

  tcb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk_i, .rst_ni, .load_i(wr_wptr), .load_val_i(reg_wdata_i[AW-1:0]),
    .step_i(ram_we), .ptr_o(wr_ptr), .wrap_o(wrap)
  );

  tcb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i, .rst_ni, .load_i(wr_rptr), .load_val_i(reg_wdata_i[AW-1:0]),
    .step_i(rd_data), .ptr_o(rd_ptr), .wrap_o()
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_en_q   <= 1'b0;
      fc_fmt_q   <= 1'b0;
      fc_stfl_q  <= 1'b0;
      fc_sttrg_q <= 1'b0;
      trig_q     <= '0;
    end else begin
      if (wr_ctrl) cap_en_q <= reg_wdata_i[0];
      if (wr_trig) trig_q   <= reg_wdata_i[CNT_W-1:0];
      if (wr_fctrl) begin
        fc_fmt_q   <= reg_wdata_i[FC_FMT];
        fc_stfl_q  <= reg_wdata_i[FC_STFL];
        fc_sttrg_q <= reg_wdata_i[FC_STTRG];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             full_q <= 1'b0;
    else if (wr_wptr)        full_q <= 1'b0;
    else if (ram_we && wrap) full_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             flush_q <= 1'b0;
    else if (wr_fctrl && reg_wdata_i[FC_FLUSH]) flush_q <= 1'b1;
    else if (flush_done)                     flush_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_q <= 1'b0;
      armed_q   <= 1'b0;
      cnt_q     <= '0;
    end else if (restart) begin
      stopped_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if ((live && stop_now) || (flush_done && fc_stfl_q)) stopped_q <= 1'b1;
      if (arm) begin
        armed_q <= 1'b1;
        cnt_q   <= trig_q;
      end else if (armed_q && hw_st) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_DEPTH: reg_rdata_o = {1'b0, 31'(DEPTH)};
      A_STAT:  reg_rdata_o[0] = full_q;
      A_RDATA: reg_rdata_o = ram_rd;
      A_RPTR:  reg_rdata_o = REG_W'(rd_ptr);
      A_WPTR:  reg_rdata_o = REG_W'(wr_ptr);
      A_TRIG:  reg_rdata_o = REG_W'(trig_q);
      A_CTRL:  reg_rdata_o[0] = cap_en_q;
      A_FSTAT: reg_rdata_o[FS_STOP] = stopped_q || !cap_en_q;
      A_FCTRL: begin
        reg_rdata_o[FC_FMT]   = fc_fmt_q;
        reg_rdata_o[FC_FLUSH] = flush_q;
        reg_rdata_o[FC_STFL]  = fc_stfl_q;
        reg_rdata_o[FC_STTRG] = fc_sttrg_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/trace_capture_buf_chk.sv
module trace_capture_buf_chk
  import tcb_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic [AW-1:0]     wr_ptr,
  input logic [AW-1:0]     rd_ptr,
  input logic              full_q,
  input logic              stopped_q,
  input logic              flush_q
);
  logic wr_acc;
  assign wr_acc = reg_req_i && reg_we_i;

  // R1
  depth_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == A_DEPTH) |-> (reg_rdata_o == REG_W'(DEPTH) && !reg_rdata_o[31]));

  // R4
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !(wr_acc && reg_addr_i == A_WPTR)) |=> full_q);

  // R5
  rd_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == A_RDATA) |=>
      (rd_ptr == (($past(rd_ptr) == AW'(DEPTH - 1)) ? '0 : $past(rd_ptr) + 1'b1)));

  // R10
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_q && !(wr_acc && (reg_addr_i == A_WPTR || reg_addr_i == A_WDATA || reg_addr_i == A_CTRL)))
      |=> $stable(wr_ptr));

  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q && wr_ptr[FRM_W-1:0] == '0 && !(wr_acc && reg_addr_i == A_FCTRL)) |=> !flush_q);
endmodule

bind trace_capture_buf trace_capture_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(reg_req_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .full_q(full_q), .stopped_q(stopped_q), .flush_q(flush_q)
);

// File: tb/trace_capture_buf_tb.sv
module trace_capture_buf_tb;
  import tcb_pkg::*;

  localparam int DEPTH = 16;
  localparam int NV    = 22;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              trace_valid = 1'b0, trigger = 1'b0;
  logic [REG_W-1:0]  trace_data = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [REG_W-1:0]  wdata = '0, rdata;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .trace_valid_i(trace_valid), .trace_data_i(trace_data),
    .trigger_i(trigger), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // {write, offset, data-or-expected}
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, A_WPTR,  32'd0},   // R6
    {1'b1, A_WDATA, 32'h11},  // R3
    {1'b1, A_WDATA, 32'h22},
    {1'b1, A_WDATA, 32'h33},
    {1'b0, A_WPTR,  32'd3},   // R3
    {1'b1, A_RPTR,  32'd0},   // R6
    {1'b0, A_RDATA, 32'h11},  // R5
    {1'b0, A_RDATA, 32'h22},
    {1'b0, A_RPTR,  32'd2},   // R5
    {1'b0, A_DEPTH, 32'd16},  // R1
    {1'b0, A_STAT,  32'd0},   // R4
    {1'b1, A_WPTR,  32'd15},
    {1'b1, A_WDATA, 32'h44},
    {1'b1, A_WDATA, 32'h55},  // wraps
    {1'b0, A_WPTR,  32'd1},   // R3
    {1'b0, A_STAT,  32'd1},   // R4
    {1'b1, A_RPTR,  32'd15},
    {1'b0, A_RDATA, 32'h44},  // R5
    {1'b0, A_RDATA, 32'h55},  // R5 wrap
    {1'b0, A_RPTR,  32'd1},
    {1'b1, A_WPTR,  32'd0},
    {1'b0, A_STAT,  32'd0}    // R4 clear
  };

  task automatic check(input string tag, input logic [REG_W-1:0] got, input logic [REG_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] exp);
    logic [REG_W-1:0] v;
    reg_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic push(input logic [REG_W-1:0] d, input logic trg);
    trace_valid = 1'b1; trace_data = d; trigger = trg;
    @(negedge clk);
    trace_valid = 1'b0; trigger = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd_chk("R11 ctrl", A_CTRL, 32'd0);
    rd_chk("R11 wptr", A_WPTR, 32'd0);
    rd_chk("R11 rptr", A_RPTR, 32'd0);
    rd_chk("R11 stat", A_STAT, 32'd0);
    rd_chk("R11 fctrl", A_FCTRL, 32'd0);
    rd_chk("R11 fstat", A_FSTAT, 32'h2);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) reg_wr(VEC[i][43:32], VEC[i][31:0]);
      else rd_chk($sformatf("R1 R3 R4 R5 R6 vector %0d", i), VEC[i][43:32], VEC[i][31:0]);
    end

    // R2 capture enabled vs disabled
    reg_wr(A_CTRL, 32'd1);
    for (int i = 0; i < 5; i++) push(32'h100 + i, 1'b0);
    rd_chk("R2 wptr after capture", A_WPTR, 32'd5);
    reg_wr(A_CTRL, 32'd0);
    push(32'hDEAD, 1'b0);
    rd_chk("R2 wptr while disabled", A_WPTR, 32'd5);
    reg_wr(A_RPTR, 32'd0);
    for (int i = 0; i < 5; i++) rd_chk("R2 stored word", A_RDATA, 32'h100 + i);

    // R4 wrap via trace stores
    reg_wr(A_WPTR, 32'd0);
    reg_wr(A_CTRL, 32'd1);
    for (int i = 0; i < 16; i++) push(32'h200 + i, 1'b0);
    rd_chk("R4 wptr wrapped", A_WPTR, 32'd0);
    rd_chk("R4 full set", A_STAT, 32'd1);
    push(32'h300, 1'b0);
    push(32'h301, 1'b0);
    rd_chk("R4 full sticky", A_STAT, 32'd1);
    reg_wr(A_RPTR, 32'd0);
    rd_chk("R3 overwrite oldest", A_RDATA, 32'h300);

    // R7 trigger countdown
    reg_wr(A_WPTR, 32'd0);
    reg_wr(A_TRIG, 32'd3);
    reg_wr(A_FCTRL, 32'h2001);
    reg_wr(A_CTRL, 32'd1);
    push(32'h400, 1'b1);
    for (int i = 1; i < 7; i++) push(32'h400 + i, 1'b0);
    rd_chk("R7 words after trigger", A_WPTR, 32'd4);
    rd_chk("R7 stopped", A_FSTAT, 32'h2);
    rd_chk("R10 ctrl still on", A_CTRL, 32'd1);

    // R8 R9 flush padding and stop
    reg_wr(A_FCTRL, 32'h1000);
    reg_wr(A_WPTR, 32'd0);
    reg_wr(A_CTRL, 32'd1);
    rd_chk("R10 restart clears stop", A_FSTAT, 32'h0);
    push(32'h500, 1'b0);
    push(32'h501, 1'b0);
    reg_wr(A_FCTRL, 32'h1040);
    rd_chk("R8 flush pending", A_FCTRL, 32'h1040);
    repeat (3) @(negedge clk);
    rd_chk("R8 flush cleared", A_FCTRL, 32'h1000);
    rd_chk("R8 padded to frame", A_WPTR, 32'd4);
    rd_chk("R9 stop after flush", A_FSTAT, 32'h2);
    reg_wr(A_RPTR, 32'd2);
    rd_chk("R8 pad zero", A_RDATA, 32'd0);
    rd_chk("R8 pad zero", A_RDATA, 32'd0);
    push(32'h502, 1'b0);
    rd_chk("R10 no store while stopped", A_WPTR, 32'd4);

    // R3 software access wins over trace
    reg_wr(A_FCTRL, 32'd0);
    reg_wr(A_CTRL, 32'd1);
    reg_wr(A_WPTR, 32'd8);
    trace_valid = 1'b1; trace_data = 32'hBAD;
    req = 1'b1; we = 1'b1; addr = A_WDATA; wdata = 32'h5A5A;
    @(negedge clk);
    trace_valid = 1'b0; req = 1'b0; we = 1'b0;
    rd_chk("R3 one store only", A_WPTR, 32'd9);
    reg_wr(A_RPTR, 32'd8);
    rd_chk("R3 software word kept", A_RDATA, 32'h5A5A);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule